// File: doc/BRIEF.md
# DMA Channel Burst Address Stepper

This block sits inside one DMA channel and produces the source address, target address and byte count of the next burst. A start pulse captures the two start addresses, the transfer length and the command bits. The block then offers one burst at a time. Each acknowledged burst moves the enabled addresses forward and takes its bytes off the remaining length. When the remaining length reaches zero, the done flag rises.

Each side is either external memory or an on-chip peripheral, as its address-type input selects. Unless byte alignment is enabled, the block clears the low address bits it presents: three bits on a memory side and two on a peripheral side. Per-side flow-control bits hold each burst back until that side's peripheral raises its request. A memory-to-memory move with a nonzero width field is refused: the block flags an error and offers no burst. The bus protocol and the data buffering belong to other blocks.

Top module: `dma_addr_stepper`

## Requirements
- R1: A cycle with `start` high captures `srcStart`, `trgStart`, `xferLen` and all command inputs. From the next cycle, a nonzero-length transfer presents its first burst at the captured addresses, with `done` low.
- R2: `burstSel` encodes the burst size as 00 = 8, 01 = 16, 10 = 32 and 11 = 32 bytes. `burstBytes` equals the smaller of that size and the remaining length.
- R3: The cycle after an accepted burst (`burstValid` and `burstAck` both high), the source address has moved up by the burst's `burstBytes` when `srcInc` was captured as 1. When `srcInc` was captured as 0, it is unchanged.
- R4: The target address follows the same rule as R3, using `trgInc`.
- R5: Each accepted burst takes `burstBytes` off the remaining length. When the remaining length is zero, `done` is high and `burstValid` is low. A start with zero length raises `done` on the next cycle.
- R6: With `alignEn` captured as 0, a side whose address-type input was 0 (memory) presents its address with bits [2:0] forced to zero.
- R7: With `alignEn` captured as 0, a side whose address-type input was 1 (peripheral) presents its address with bits [1:0] forced to zero.
- R8: With `alignEn` captured as 1, both addresses are presented byte-exact.
- R9: With `srcFlow` captured as 1, `burstValid` stays low while `srcReq` is low.
- R10: With `trgFlow` captured as 1, `burstValid` stays low while `trgReq` is low.
- R11: When both address-type inputs are 0 and `width` is nonzero at start, `cfgError` rises and no burst is offered. A nonzero width with a peripheral side raises no error.
- R12: After reset, `burstValid`, `done` and `cfgError` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load pulse for a new transfer |
| srcStart | input | ADDR_W | Source start address |
| trgStart | input | ADDR_W | Target start address |
| xferLen | input | LEN_W | Transfer length in bytes |
| burstSel | input | 2 | Burst size code |
| srcInc | input | 1 | Source address steps after each burst |
| trgInc | input | 1 | Target address steps after each burst |
| srcIsPeriph | input | 1 | Source is a peripheral (1) or memory (0) |
| trgIsPeriph | input | 1 | Target is a peripheral (1) or memory (0) |
| srcFlow | input | 1 | Gate bursts on the source request |
| trgFlow | input | 1 | Gate bursts on the target request |
| alignEn | input | 1 | Disable low-bit masking |
| width | input | 2 | Width field; must be 00 for memory-to-memory |
| srcReq | input | 1 | Source peripheral request |
| trgReq | input | 1 | Target peripheral request |
| burstAck | input | 1 | Bus side accepted the offered burst |
| burstValid | output | 1 | A burst is offered |
| burstSrcAddr | output | ADDR_W | Source address of the current burst |
| burstTrgAddr | output | ADDR_W | Target address of the current burst |
| burstBytes | output | LEN_W | Byte count of the current burst |
| done | output | 1 | Remaining length is zero |
| cfgError | output | 1 | Invalid width for a memory-to-memory move |

## Verification
Several properties are checked on every cycle. Flow-control gating, the masking of low address bits for each side type, the bound on the burst byte count, the blocking of bursts while in error or done, and the holding of a non-incrementing address across an accepted burst are all covered this way. The exact step amounts need the bench's directed scenarios. So do the shortened last burst, the burst-size encoding, the zero-length start, and the difference between a refused memory-to-memory width and an accepted peripheral one.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } stepStrobes_t;

  typedef enum logic [1:0] {
    BURST_8   = 2'b00,
    BURST_16  = 2'b01,
    BURST_32  = 2'b10,
    BURST_32B = 2'b11
  } burstSel_e;
endpackage

// File: rtl/dma_step_datapath.sv
module dma_step_datapath
  import dma_step_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepStrobes_t      strobes,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] trgStart,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [1:0]        burstSel,
  input  logic              srcInc,
  input  logic              trgInc,
  input  logic              srcIsPeriph,
  input  logic              trgIsPeriph,
  input  logic              alignEn,
  output logic [ADDR_W-1:0] burstSrcAddr,
  output logic [ADDR_W-1:0] burstTrgAddr,
  output logic [LEN_W-1:0]  burstBytes,
  output logic              remZero,
  output logic [1:0]        incQ,
  output logic [1:0]        perQ,
  output logic              alignQ
);
  localparam int MEM_LSB = 3;
  localparam int PER_LSB = 2;
  localparam int NUM_SIDES = 2;
  localparam logic [ADDR_W-1:0] MEM_MASK = ADDR_W'((1 << MEM_LSB) - 1);
  localparam logic [ADDR_W-1:0] PER_MASK = ADDR_W'((1 << PER_LSB) - 1);

  burstSel_e   sizeQ;
  logic [LEN_W-1:0] remQ;
  logic [LEN_W-1:0] burstSize;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] startAddr;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addrQ;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] addrOut;

  assign startAddr[0] = srcStart;
  assign startAddr[1] = trgStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ  <= BURST_8;
      incQ   <= '0;
      perQ   <= '0;
      alignQ <= 1'b0;
      remQ   <= '0;
    end else if (strobes.load) begin
      sizeQ  <= burstSel_e'(burstSel);
      incQ   <= {trgInc, srcInc};
      perQ   <= {trgIsPeriph, srcIsPeriph};
      alignQ <= alignEn;
      remQ   <= xferLen;
    end else if (strobes.step) begin
      remQ   <= remQ - burstBytes;
    end
  end

  always_comb begin
    case (sizeQ)
      BURST_8:  burstSize = LEN_W'(8);
      BURST_16: burstSize = LEN_W'(16);
      default:  burstSize = LEN_W'(32);
    endcase
  end

  assign burstBytes = (remQ < burstSize) ? remQ : burstSize;
  assign remZero    = (remQ == '0);

  for (genvar g = 0; g < NUM_SIDES; g++) begin : gLane
    logic [ADDR_W-1:0] lowMask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          addrQ[g] <= '0;
      else if (strobes.load)              addrQ[g] <= startAddr[g];
      else if (strobes.step && incQ[g])   addrQ[g] <= addrQ[g] + ADDR_W'(burstBytes);
    end

    assign lowMask    = alignQ ? '0 : (perQ[g] ? PER_MASK : MEM_MASK);
    assign addrOut[g] = addrQ[g] & ~lowMask;
  end

  assign burstSrcAddr = addrOut[0];
  assign burstTrgAddr = addrOut[1];
endmodule

// File: rtl/dma_step_ctrl.sv
module dma_step_ctrl
  import dma_step_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   width,
  input  logic         srcIsPeriph,
  input  logic         trgIsPeriph,
  input  logic         srcFlow,
  input  logic         trgFlow,
  input  logic         srcReq,
  input  logic         trgReq,
  input  logic         burstAck,
  input  logic         remZero,
  output stepStrobes_t strobes,
  output logic         burstValid,
  output logic         done,
  output logic         cfgError,
  output logic [1:0]   flowQ
);
  logic loadedQ;
  logic errQ;
  logic memToMem;
  logic reqOk;

  assign memToMem = !srcIsPeriph && !trgIsPeriph;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadedQ <= 1'b0;
      errQ    <= 1'b0;
      flowQ   <= '0;
    end else if (start) begin
      loadedQ <= 1'b1;
      errQ    <= memToMem && (width != 2'b00);
      flowQ   <= {trgFlow, srcFlow};
    end
  end

  assign reqOk      = (!flowQ[0] || srcReq) && (!flowQ[1] || trgReq);
  assign burstValid = loadedQ && !errQ && !remZero && reqOk;
  assign done       = loadedQ && !errQ && remZero;
  assign cfgError   = errQ;

  assign strobes.load = start;
  assign strobes.step = burstValid && burstAck && !start;
endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper
  import dma_step_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] trgStart,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [1:0]        burstSel,
  input  logic              srcInc,
  input  logic              trgInc,
  input  logic              srcIsPeriph,
  input  logic              trgIsPeriph,
  input  logic              srcFlow,
  input  logic              trgFlow,
  input  logic              alignEn,
  input  logic [1:0]        width,
  input  logic              srcReq,
  input  logic              trgReq,
  input  logic              burstAck,
  output logic              burstValid,
  output logic [ADDR_W-1:0] burstSrcAddr,
  output logic [ADDR_W-1:0] burstTrgAddr,
  output logic [LEN_W-1:0]  burstBytes,
  output logic              done,
  output logic              cfgError
);
  stepStrobes_t strobes;
  logic         remZero;
  logic [1:0]   flowQ;
  logic [1:0]   incQ;
  logic [1:0]   perQ;
  logic         alignQ;

  dma_step_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .width(width),
    .srcIsPeriph(srcIsPeriph), .trgIsPeriph(trgIsPeriph),
    .srcFlow(srcFlow), .trgFlow(trgFlow), .srcReq(srcReq), .trgReq(trgReq),
    .burstAck(burstAck), .remZero(remZero), .strobes(strobes),
    .burstValid(burstValid), .done(done), .cfgError(cfgError), .flowQ(flowQ)
  );

  dma_step_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .srcStart(srcStart), .trgStart(trgStart), .xferLen(xferLen),
    .burstSel(burstSel), .srcInc(srcInc), .trgInc(trgInc),
    .srcIsPeriph(srcIsPeriph), .trgIsPeriph(trgIsPeriph), .alignEn(alignEn),
    .burstSrcAddr(burstSrcAddr), .burstTrgAddr(burstTrgAddr),
    .burstBytes(burstBytes), .remZero(remZero),
    .incQ(incQ), .perQ(perQ), .alignQ(alignQ)
  );
endmodule

// File: rtl/dma_step_chk.sv
module dma_step_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              burstAck,
  input logic              burstValid,
  input logic              done,
  input logic              cfgError,
  input logic              srcReq,
  input logic              trgReq,
  input logic [1:0]        flowQ,
  input logic [1:0]        incQ,
  input logic [1:0]        perQ,
  input logic              alignQ,
  input logic [ADDR_W-1:0] burstSrcAddr,
  input logic [ADDR_W-1:0] burstTrgAddr,
  input logic [LEN_W-1:0]  burstBytes
);
  // R9
  src_flow_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && flowQ[0] |-> srcReq);

  // R10
  trg_flow_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && flowQ[1] |-> trgReq);

  // R11
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !burstValid);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !burstValid);

  // R2
  bytes_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> (burstBytes != '0) && (burstBytes <= LEN_W'(32)));

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && burstAck && !start && !incQ[0] |=> $stable(burstSrcAddr));

  // R4
  trg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && burstAck && !start && !incQ[1] |=> $stable(burstTrgAddr));

  // R6
  src_mem_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignQ && !perQ[0] |-> burstSrcAddr[2:0] == 3'b000);

  // R6
  trg_mem_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignQ && !perQ[1] |-> burstTrgAddr[2:0] == 3'b000);

  // R7
  src_per_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignQ && perQ[0] |-> burstSrcAddr[1:0] == 2'b00);

  // R7
  trg_per_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !alignQ && perQ[1] |-> burstTrgAddr[1:0] == 2'b00);
endmodule

bind dma_addr_stepper dma_step_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .burstAck(burstAck),
  .burstValid(burstValid), .done(done), .cfgError(cfgError),
  .srcReq(srcReq), .trgReq(trgReq), .flowQ(flowQ), .incQ(incQ),
  .perQ(perQ), .alignQ(alignQ), .burstSrcAddr(burstSrcAddr),
  .burstTrgAddr(burstTrgAddr), .burstBytes(burstBytes)
);

// File: tb/tb_dma_addr_stepper.sv
module tb_dma_addr_stepper;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] srcStart = '0, trgStart = '0;
  logic [LEN_W-1:0]  xferLen = '0;
  logic [1:0] burstSel = '0, width = '0;
  logic srcInc = 0, trgInc = 0, srcIsPeriph = 0, trgIsPeriph = 0;
  logic srcFlow = 0, trgFlow = 0, alignEn = 0, srcReq = 0, trgReq = 0, burstAck = 0;
  logic burstValid, done, cfgError;
  logic [ADDR_W-1:0] burstSrcAddr, burstTrgAddr;
  logic [LEN_W-1:0] burstBytes;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  dma_addr_stepper #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doStart(input logic [31:0] s, input logic [31:0] t, input int len,
                         input logic [1:0] sel, input logic sI, input logic tI,
                         input logic sP, input logic tP, input logic sF, input logic tF,
                         input logic al, input logic [1:0] w);
    srcStart = s; trgStart = t; xferLen = LEN_W'(len); burstSel = sel;
    srcInc = sI; trgInc = tI; srcIsPeriph = sP; trgIsPeriph = tP;
    srcFlow = sF; trgFlow = tF; alignEn = al; width = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ackOnce();
    burstAck = 1'b1;
    @(negedge clk);
    burstAck = 1'b0;
  endtask

  task automatic testResetState();
    check("R12", "valid", 32'(burstValid), 0);
    check("R12", "done", 32'(done), 0);
    check("R12", "error", 32'(cfgError), 0);
  endtask

  task automatic testMemToMem();
    doStart(32'h1000, 32'h2000, 40, 2'b10, 1, 1, 0, 0, 0, 0, 0, 2'b00);
    check("R1", "valid", 32'(burstValid), 1);
    check("R1", "done", 32'(done), 0);
    check("R1", "src", burstSrcAddr, 32'h1000);
    check("R2", "bytes 32", 32'(burstBytes), 32);
    ackOnce();
    check("R3", "src step", burstSrcAddr, 32'h1020);
    check("R4", "trg step", burstTrgAddr, 32'h2020);
    check("R2", "short last burst", 32'(burstBytes), 8);
    ackOnce();
    check("R5", "done", 32'(done), 1);
    check("R5", "valid drop", 32'(burstValid), 0);
  endtask

  task automatic testSrcFlowMask();
    srcReq = 1'b0;
    doStart(32'h4003, 32'h3005, 20, 2'b00, 0, 1, 1, 0, 1, 0, 0, 2'b00);
    check("R9", "held without req", 32'(burstValid), 0);
    check("R7", "periph mask", burstSrcAddr, 32'h4000);
    check("R6", "mem mask", burstTrgAddr, 32'h3000);
    srcReq = 1'b1;
    #1;
    check("R9", "valid with req", 32'(burstValid), 1);
    check("R2", "bytes 8", 32'(burstBytes), 8);
    ackOnce();
    check("R3", "src fixed", burstSrcAddr, 32'h4000);
    check("R6", "trg stepped masked", burstTrgAddr, 32'h3008);
    ackOnce();
    check("R2", "remainder 4", 32'(burstBytes), 4);
    check("R6", "trg again", burstTrgAddr, 32'h3010);
    ackOnce();
    check("R5", "done", 32'(done), 1);
    srcReq = 1'b0;
  endtask

  task automatic testTrgFlowAlign();
    trgReq = 1'b0;
    doStart(32'h5001, 32'h6002, 16, 2'b01, 1, 0, 0, 1, 0, 1, 1, 2'b00);
    check("R10", "held without req", 32'(burstValid), 0);
    trgReq = 1'b1;
    #1;
    check("R10", "valid with req", 32'(burstValid), 1);
    check("R8", "src exact", burstSrcAddr, 32'h5001);
    check("R8", "trg exact", burstTrgAddr, 32'h6002);
    check("R2", "bytes 16", 32'(burstBytes), 16);
    ackOnce();
    check("R4", "trg fixed", burstTrgAddr, 32'h6002);
    check("R5", "done", 32'(done), 1);
    trgReq = 1'b0;
  endtask

  task automatic testWidthError();
    doStart(32'h1000, 32'h2000, 16, 2'b00, 1, 1, 0, 0, 0, 0, 0, 2'b01);
    check("R11", "error", 32'(cfgError), 1);
    check("R11", "no burst", 32'(burstValid), 0);
    check("R11", "no done", 32'(done), 0);
    doStart(32'h1000, 32'h2000, 16, 2'b00, 0, 1, 1, 0, 0, 0, 0, 2'b01);
    check("R11", "periph no error", 32'(cfgError), 0);
    check("R11", "periph burst", 32'(burstValid), 1);
  endtask

  task automatic testZeroAndSel3();
    doStart(32'h100, 32'h200, 0, 2'b10, 1, 1, 0, 0, 0, 0, 0, 2'b00);
    check("R5", "zero length done", 32'(done), 1);
    check("R5", "zero length idle", 32'(burstValid), 0);
    doStart(32'h7000, 32'h8000, 64, 2'b11, 1, 1, 0, 0, 0, 0, 0, 2'b00);
    check("R2", "code 11 bytes", 32'(burstBytes), 32);
    ackOnce();
    check("R3", "src +32", burstSrcAddr, 32'h7020);
    check("R2", "second 32", 32'(burstBytes), 32);
    ackOnce();
    check("R5", "done after 64", 32'(done), 1);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testResetState();
    rstN = 1'b1;
    @(negedge clk);
    testMemToMem();
    testSrcFlowMask();
    testTrgFlowAlign();
    testWidthError();
    testZeroAndSel3();
    finishRun();
  end
endmodule